// File: doc/BRIEF.md
# Daisy-chain converter readout controller

This block sits on the host side of a chain of serial 16-bit converters that share one convert line and one three-wire port (convert, serial clock, data in). On a start pulse it prepares the serial clock level that tells the converters whether to use the busy flag, raises the convert line, and keeps that line high until the whole chain has been read. In the mode without the busy flag it waits a fixed number of system clocks for the slowest conversion to finish. In the mode with the busy flag it waits for the data line to go high. A second, longer window guards that wait.

Once data are ready, the controller produces the serial clock from the system clock through a half-period divider. It samples the data line at every falling edge it creates and shifts the bits into an internal register. When the last bit arrives it drops the convert line and presents one 16-bit word per converter together with a one-cycle valid strobe. If the busy flag never comes, it raises an error flag and goes back to idle without clocking any data.

Top module: `chain_adc_reader`

## Requirements
- R1: While reset is asserted and after it is released, `cnv`, `sck`, `words_valid` and `timeout_err` are low and `words` is all zeros.
- R2: On a `start` pulse in idle, `sck` is set to the level of `use_busy` (high selects the busy-flag option) at least HALF_CYC clocks before `cnv` rises, and `sck` does not change in the cycle `cnv` rises.
- R3: `cnv` stays high from its rising edge until after the last serial clock falling edge. It falls in the same cycle that `words_valid` or `timeout_err` rises, and `sck` is low from that cycle on.
- R4: With `use_busy` low, the first `sck` rising edge comes CONV_CYC + HALF_CYC clocks after `cnv` rises, and exactly 16×N_CONV falling edges are issued.
- R5: With `use_busy` high, the controller clocks only after `sdo_in` is seen high. It issues 16×N_CONV+1 falling edges, and the first sampled bit (the busy flag) is dropped. The first falling edge comes HALF_CYC+1 clocks after the cycle in which `sdo_in` goes high.
- R6: `sdo_in` is sampled at the system clock edge that drives `sck` from high to low, so the bit captured is the one present before the converters shift.
- R7: Bits arrive MSB first. `words[15:0]` holds the converter nearest the host (the first 16 data bits read), and `words[16k+15:16k]` holds converter k.
- R8: Every high and every low phase of `sck` lasts at least HALF_CYC system clocks.
- R9: With `use_busy` high, if `sdo_in` is still low at the end of BUSY_TMO clocks after `cnv` rises, `timeout_err` is set, `cnv` falls, no serial clock is issued and `words` keeps its old value. A high `sdo_in` in the last cycle of that window still counts as ready. The flag clears on the next accepted `start`.
- R10: A `start` pulse while a conversion or readback is in progress is ignored. The data read and the edge count are unchanged, and no new conversion follows.
- R11: `words_valid` is a single-cycle pulse, and `words` holds its value until the next successful readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to convert and read the chain |
| use_busy | input | 1 | Selects the busy-flag option for the requested conversion |
| sdo_in | input | 1 | Serial data from the converter nearest the host |
| cnv | output | 1 | Convert line shared by all converters |
| sck | output | 1 | Serial clock to the chain |
| words | output | 16×N_CONV | Results, converter k in bits 16k+15:16k |
| words_valid | output | 1 | One-cycle strobe when `words` is updated |
| timeout_err | output | 1 | Busy flag did not appear within BUSY_TMO clocks |

## Verification
The busy-flag wait and the busy timeout can resolve in the same system clock, when `sdo_in` rises in the final cycle of the BUSY_TMO window. The bench's converter model raises its flag exactly BUSY_TMO−1 clocks after the convert edge, and then exactly BUSY_TMO clocks after it. In the first case the data must be read in full and no error raised. In the second the error must be raised with no serial clock and no change to the words. The bench judges both cases by the data words, the count of falling edges seen by the model, and the state of the convert line.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;

  localparam int CADC_WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_READ,
    ST_DONE
  } cadc_state_e;

endpackage

// File: rtl/cadc_tick_count.sv
// Wrapping cycle counter: counts enabled cycles and flags the last one of
// every LIMIT-cycle window. Clears whenever it is not enabled.
module cadc_tick_count #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic hit
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign hit = en && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    if (!en || hit) cnt_d = '0;
    else            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cadc_word_capture.sv
// Serial-to-parallel capture: shifts sampled bits in MSB first and reorders
// them so the first word read lands in the lowest slice of the output.
module cadc_word_capture #(
  parameter int N_CONV = 2,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic                     bit_in,
  input  logic                     load,
  output logic [N_CONV*WORD_W-1:0] words
);

  localparam int TOT = N_CONV * WORD_W;

  logic [TOT-1:0] shreg_q;
  logic [TOT-1:0] ordered;

  for (genvar k = 0; k < N_CONV; k++) begin : g_slot
    assign ordered[k*WORD_W +: WORD_W] = shreg_q[TOT-1-k*WORD_W -: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (shift_en) begin
      shreg_q <= {shreg_q[TOT-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words <= '0;
    end else if (load) begin
      words <= ordered;
    end
  end

endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader
  import chain_adc_pkg::*;
#(
  parameter int N_CONV   = 2,
  parameter int HALF_CYC = 2,
  parameter int CONV_CYC = 40,
  parameter int BUSY_TMO = 60
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          use_busy,
  input  logic                          sdo_in,
  output logic                          cnv,
  output logic                          sck,
  output logic [N_CONV*CADC_WORD_W-1:0] words,
  output logic                          words_valid,
  output logic                          timeout_err
);

  localparam int TOTAL_BITS = N_CONV * CADC_WORD_W;
  localparam int BW         = $clog2(TOTAL_BITS + 2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_sys_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sys_n = rsync_q[1];

  cadc_state_e   st_q, st_d;
  logic          sck_q, sck_d;
  logic          cnv_q, cnv_d;
  logic          mode_q, mode_d;
  logic          valid_q, valid_d;
  logic          err_q, err_d;
  logic [BW-1:0] bits_q, bits_d;
  logic [BW-1:0] last_bit;
  logic          shift_req;
  logic          shift_en;
  logic          load;
  logic          half_hit;
  logic          conv_hit;
  logic          tmo_hit;

  cadc_tick_count #(.LIMIT(HALF_CYC)) u_half (
    .clk   (clk),
    .rst_n (rst_sys_n),
    .en    ((st_q == ST_SETUP) || (st_q == ST_READ)),
    .hit   (half_hit)
  );

  cadc_tick_count #(.LIMIT(CONV_CYC)) u_conv (
    .clk   (clk),
    .rst_n (rst_sys_n),
    .en    ((st_q == ST_WAIT) && !mode_q),
    .hit   (conv_hit)
  );

  cadc_tick_count #(.LIMIT(BUSY_TMO)) u_tmo (
    .clk   (clk),
    .rst_n (rst_sys_n),
    .en    ((st_q == ST_WAIT) && mode_q),
    .hit   (tmo_hit)
  );

  assign last_bit = BW'(TOTAL_BITS - 1) + BW'(mode_q);
  // the first bit captured in busy-flag mode is the flag itself
  assign shift_en = shift_req && !(mode_q && (bits_q == '0));

  always_comb begin
    st_d      = st_q;
    sck_d     = sck_q;
    cnv_d     = cnv_q;
    mode_d    = mode_q;
    err_d     = err_q;
    bits_d    = bits_q;
    valid_d   = 1'b0;
    shift_req = 1'b0;
    load      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_SETUP;
          mode_d = use_busy;
          sck_d  = use_busy;
          err_d  = 1'b0;
          bits_d = '0;
        end
      end
      ST_SETUP: begin
        if (half_hit) begin
          cnv_d = 1'b1;
          st_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (mode_q) begin
          if (sdo_in) begin
            st_d = ST_READ;
          end else if (tmo_hit) begin
            err_d = 1'b1;
            cnv_d = 1'b0;
            sck_d = 1'b0;
            st_d  = ST_IDLE;
          end
        end else if (conv_hit) begin
          st_d = ST_READ;
        end
      end
      ST_READ: begin
        if (half_hit) begin
          sck_d = !sck_q;
          if (sck_q) begin
            shift_req = 1'b1;
            bits_d    = bits_q + 1'b1;
            if (bits_q == last_bit) st_d = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        cnv_d   = 1'b0;
        valid_d = 1'b1;
        load    = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sys_n) begin
    if (!rst_sys_n) begin
      st_q    <= ST_IDLE;
      sck_q   <= 1'b0;
      cnv_q   <= 1'b0;
      mode_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      bits_q  <= '0;
    end else begin
      st_q    <= st_d;
      sck_q   <= sck_d;
      cnv_q   <= cnv_d;
      mode_q  <= mode_d;
      valid_q <= valid_d;
      err_q   <= err_d;
      bits_q  <= bits_d;
    end
  end

  cadc_word_capture #(.N_CONV(N_CONV), .WORD_W(CADC_WORD_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sys_n),
    .shift_en (shift_en),
    .bit_in   (sdo_in),
    .load     (load),
    .words    (words)
  );

  assign cnv         = cnv_q;
  assign sck         = sck_q;
  assign words_valid = valid_q;
  assign timeout_err = err_q;

endmodule

// File: rtl/cadc_chain_chk.sv
module cadc_chain_chk #(
  parameter int HALF_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cnv,
  input logic sck,
  input logic words_valid,
  input logic timeout_err
);

  localparam int HW = $clog2(HALF_CYC + 1) + 1;

  logic          prev_sck;
  logic [HW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sck <= 1'b0;
      held     <= HW'(HALF_CYC);
    end else begin
      prev_sck <= sck;
      if (sck != prev_sck)           held <= HW'(1);
      else if (held < HW'(HALF_CYC)) held <= held + 1'b1;
    end
  end

  // R8
  sck_phase_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != prev_sck) |-> (held >= HW'(HALF_CYC)));

  // R2
  cnv_edge_sck_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv) |-> $stable(sck));

  // R3
  sck_fall_under_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (cnv || timeout_err));

  // R3
  cnv_fall_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv) |-> !sck);

  // R11
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    words_valid |=> !words_valid);

  // R9
  err_with_cnv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> ($fell(cnv) && !words_valid));

endmodule

bind chain_adc_reader cadc_chain_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnv         (cnv),
  .sck         (sck),
  .words_valid (words_valid),
  .timeout_err (timeout_err)
);

// File: tb/sim_chain_adc_reader.sv
`timescale 1ns/1ps
module sim_chain_adc_reader;

  localparam int N_CONV   = 2;
  localparam int HALF_CYC = 2;
  localparam int CONV_CYC = 40;
  localparam int BUSY_TMO = 60;
  localparam int NBITS    = 16 * N_CONV;

  // {use_busy, data}: data[31:16] is the converter nearest the host
  localparam logic [32:0] VEC_T [0:4] = '{
    33'h0_A5C3_0F01,
    33'h1_1234_FEDC,
    33'h0_8000_7FFF,
    33'h1_0000_FFFF,
    33'h1_FFFF_0001
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic use_busy;
  logic sdo_in;
  logic cnv;
  logic sck;
  logic [NBITS-1:0] words;
  logic words_valid;
  logic timeout_err;

  always #10 clk = ~clk;

  chain_adc_reader #(
    .N_CONV(N_CONV), .HALF_CYC(HALF_CYC), .CONV_CYC(CONV_CYC), .BUSY_TMO(BUSY_TMO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .use_busy(use_busy), .sdo_in(sdo_in),
    .cnv(cnv), .sck(sck), .words(words), .words_valid(words_valid),
    .timeout_err(timeout_err)
  );

  // behavioural chain of converters, seen as one long shift register
  logic [31:0] mdata;
  int          lat;
  logic [31:0] sh;
  logic        prev_sck, prev_cnv, mready, mbusy, mode_seen;
  int          mcnt;
  int          falls;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; prev_sck <= 1'b0; prev_cnv <= 1'b0; mready <= 1'b0;
      mbusy <= 1'b0; mode_seen <= 1'b0; mcnt <= 0; falls <= 0;
    end else begin
      prev_sck <= sck;
      prev_cnv <= cnv;
      if (!cnv) begin
        sh <= mdata; mcnt <= 0; mready <= 1'b0; mbusy <= 1'b0;
      end else begin
        if (!prev_cnv) begin
          mbusy     <= sck;
          mode_seen <= sck;
        end
        if (!mready) begin
          if (mcnt == lat - 1) mready <= 1'b1;
          mcnt <= mcnt + 1;
        end
        if (prev_sck && !sck && mready) begin
          falls <= falls + 1;
          if (mbusy) mbusy <= 1'b0;
          else       sh <= {sh[30:0], 1'b0};
        end
      end
    end
  end

  assign sdo_in = (cnv && mready) ? (mbusy ? 1'b1 : sh[31]) : 1'b0;

  int n_chk;
  int n_fail;
  bit wd_hit;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input bit mode);
    @(negedge clk);
    use_busy = mode;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic run_one(input bit mode, input logic [31:0] data, input int latv,
                         input bit want_err, input bit poke);
    int base_falls;
    int d;
    int guard;
    logic [NBITS-1:0] exp_w;
    logic [NBITS-1:0] old_w;
    exp_w = {data[15:0], data[31:16]};
    old_w = words;
    mdata = data;
    lat   = latv;
    base_falls = falls;
    pulse_start(mode);
    guard = 0;
    while (!cnv && guard < 100) begin @(negedge clk); guard++; end
    chk(cnv, "R2 cnv raised after start", 64'(cnv), 64'd1);
    if (!want_err) begin
      d = 0;
      if (mode) begin
        while (sck && d < 1000) begin @(negedge clk); d++; end
        chk(d == latv + HALF_CYC + 1, "R5 first fall after busy flag",
            64'(d), 64'(latv + HALF_CYC + 1));
      end else begin
        while (!sck && d < 1000) begin @(negedge clk); d++; end
        chk(d == CONV_CYC + HALF_CYC, "R4 R8 first rise after fixed wait",
            64'(d), 64'(CONV_CYC + HALF_CYC));
      end
    end
    if (poke) pulse_start(!mode);
    guard = 0;
    while (!words_valid && !timeout_err && guard < 2000) begin @(negedge clk); guard++; end
    chk(mode_seen == mode, "R2 sck level at cnv edge", 64'(mode_seen), 64'(mode));
    if (!want_err) begin
      chk(words_valid, "R11 valid strobe", 64'(words_valid), 64'd1);
      chk(!cnv, "R3 cnv drops with valid", 64'(cnv), 64'd0);
      chk(words == exp_w, "R6 R7 words", 64'(words), 64'(exp_w));
      chk(!timeout_err, "R9 no error", 64'(timeout_err), 64'd0);
      chk(falls - base_falls == NBITS + int'(mode), "R4 R5 falling edge count",
          64'(falls - base_falls), 64'(NBITS + int'(mode)));
      @(negedge clk);
      chk(!words_valid, "R11 valid one cycle", 64'(words_valid), 64'd0);
      repeat (12) @(negedge clk);
      chk(!cnv && !sck, "R10 no restart after ignored start", 64'({cnv, sck}), 64'd0);
      chk(words == exp_w, "R11 words held", 64'(words), 64'(exp_w));
    end else begin
      chk(timeout_err, "R9 timeout flag", 64'(timeout_err), 64'd1);
      chk(!cnv && !sck, "R9 R3 lines low after timeout", 64'({cnv, sck}), 64'd0);
      chk(falls == base_falls, "R9 no clocks after timeout", 64'(falls - base_falls), 64'd0);
      chk(words == old_w, "R9 words kept", 64'(words), 64'(old_w));
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; wd_hit = 1'b0;
    rst_n = 1'b0; start = 1'b0; use_busy = 1'b0; mdata = '0; lat = 10;
    fork
      begin
        repeat (3) @(negedge clk);
        chk({cnv, sck, words_valid, timeout_err} == 4'b0, "R1 outputs in reset",
            64'({cnv, sck, words_valid, timeout_err}), 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk({cnv, sck, words_valid, timeout_err} == 4'b0 && words == '0,
            "R1 state after reset", 64'(words), 64'd0);
        // main table
        foreach (VEC_T[i]) run_one(VEC_T[i][32], VEC_T[i][31:0], 10, 1'b0, 1'b0);
        // busy flag in the last cycle of the window still wins (R9 R5)
        run_one(1'b1, 32'h5A5A_C3C3, BUSY_TMO - 1, 1'b0, 1'b0);
        // one cycle later: timeout (R9)
        run_one(1'b1, 32'h0BAD_F00D, BUSY_TMO, 1'b1, 1'b0);
        // next start clears the flag (R9)
        run_one(1'b0, 32'h7E81_1234, 10, 1'b0, 1'b0);
        // start while busy is ignored (R10), both modes
        run_one(1'b0, 32'hCAFE_0042, 10, 1'b0, 1'b1);
        run_one(1'b1, 32'h0042_CAFE, 7, 1'b0, 1'b1);
      end
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule